// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Controller

This block sequences the commands for one DRAM bank and keeps track of the row latched in that bank's sense amplifiers. A request carries a read/write flag, a row index and a column address. The request is taken over a valid/ready handshake, and only one request is in service at a time. The controller compares the requested row with the row that is open, if any. It then issues the shortest command sequence that serves the access: a column command alone, an activate followed by a column command, or a precharge, then an activate, then a column command. Each phase holds for a fixed number of clock cycles, and every phase length is a parameter.

A build-time parameter selects the page policy. With the open-page policy, the activated row stays latched after the access, so a later request to the same row costs only the column phase. With the close-page policy, the bank is precharged in the background as soon as each access finishes, so every access finds the bank empty. A request that arrives while that precharge is still running waits until it is complete. Each access ends with a one-cycle completion pulse and a code that says which of the three latency cases applied. Three saturating counters accumulate the number of accesses in each case.

Top module: `dram_rowbuf_ctrl`

## Requirements
- R1: After reset, ready is high, done is low, no command is issued, all three counters read zero and no row is open. The first access is therefore classified as a miss on a precharged bank.
- R2: A request to the row that is currently open is a hit. It issues one column command and no precharge or activate. Done rises T_COL cycles after the accepting clock edge, with outcome code 0.
- R3: A request to an idle, precharged bank issues one activate and then one column command. Done rises T_ACT+T_COL cycles after acceptance, with outcome code 1.
- R4: A request to a row other than the open one issues a precharge, an activate and a column command, in that order. Done rises T_PRE+T_ACT+T_COL cycles after acceptance, with outcome code 2. Each activate comes at least T_PRE cycles after the last precharge, and each column command comes at least T_ACT cycles after the last activate.
- R5: With the open-page policy, the activated row stays open after the access. A later request to the same row is a hit, and a request to any other row is a conflict.
- R6: With the close-page policy, a precharge command is issued in the same cycle as every done pulse. Every access reports outcome code 1, and the hit and conflict counters stay at zero.
- R7: With the close-page policy, a request accepted while the background precharge is still running waits until that precharge has lasted T_PRE cycles before it activates. Done then rises at max(A, E+T_PRE)+T_ACT+T_COL, where A is the accepting edge and E is the edge that produced the previous done.
- R8: Ready is high only while the block is idle. It falls on the edge that accepts a request and stays low until the done cycle.
- R9: Done is a single-cycle pulse, and the outcome code is valid in that cycle.
- R10: The column command is the write strobe for a write request and the read strobe for a read request. The address bus carries the requested row during the activate and the requested column during the column command. At most one command strobe is high in any cycle.
- R11: The hit, miss and conflict counters each increase by one when an access of their class completes. Each counter holds at its all-ones value once it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle and able to accept a request |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_row_i | input | ROW_W | Requested row index |
| req_col_i | input | COL_W | Requested column address |
| cmd_pre_o | output | 1 | Precharge command strobe |
| cmd_act_o | output | 1 | Activate (row access) command strobe |
| cmd_rd_o | output | 1 | Read column command strobe |
| cmd_wr_o | output | 1 | Write column command strobe |
| cmd_row_o | output | ROW_W | Row address for the activate |
| cmd_col_o | output | COL_W | Column address for the column command |
| done_o | output | 1 | One-cycle completion pulse |
| outcome_o | output | 2 | 0 hit, 1 miss on precharged bank, 2 conflict |
| hit_cnt_o | output | CNT_W | Saturating count of hits |
| miss_cnt_o | output | CNT_W | Saturating count of misses on a precharged bank |
| conf_cnt_o | output | CNT_W | Saturating count of conflicts |

## Verification
A corrupted open-row register or row-valid flag shows up on the next request. That request gets the wrong outcome code, and its done pulse comes early or late by whole phase lengths. A missing or extra precharge or activate strobe appears in the same access. A phase timer that is off by a cycle shifts the done pulse by exactly one cycle. The scoreboard therefore compares both the outcome code and the exact done cycle of every access, and counts the strobes between consecutive done pulses. A background precharge that is too short in close-page mode shows as a done pulse earlier than the computed maximum.

// File: rtl/dram_rb_pkg.sv
package dram_rb_pkg;
  typedef enum logic [1:0] {
    RB_HIT      = 2'd0,
    RB_EMPTY    = 2'd1,
    RB_CONFLICT = 2'd2
  } rb_outc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_ACT,
    ST_COL
  } rb_state_e;

  localparam int unsigned RB_NUM_OUTC = 3;
endpackage

// File: rtl/dram_rb_phase_timer.sv
module dram_rb_phase_timer #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dram_rb_bg_pre.sv
module dram_rb_bg_pre #(
  parameter int unsigned T_PRE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic long_o
);
  localparam int unsigned BW = $clog2(T_PRE + 1);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= BW'(T_PRE);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // more than one precharge cycle still outstanding
  assign long_o = (cnt_q > BW'(1));
endmodule

// File: rtl/dram_rb_row_track.sv
module dram_rb_row_track
  import dram_rb_pkg::*;
#(
  parameter int unsigned ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] set_row_i,
  input  logic [ROW_W-1:0] look_row_i,
  output rb_outc_e         look_outc_o
);
  logic             valid_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      row_q   <= '0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      row_q   <= set_row_i;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end
  end

  always_comb begin
    if (!valid_q)                 look_outc_o = RB_EMPTY;
    else if (row_q == look_row_i) look_outc_o = RB_HIT;
    else                          look_outc_o = RB_CONFLICT;
  end
endmodule

// File: rtl/dram_rb_sat_cnt.sv
module dram_rb_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (inc_i && cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dram_rowbuf_ctrl.sv
module dram_rowbuf_ctrl
  import dram_rb_pkg::*;
#(
  parameter int unsigned ROW_W      = 14,
  parameter int unsigned COL_W      = 10,
  parameter int unsigned T_PRE      = 4,
  parameter int unsigned T_ACT      = 4,
  parameter int unsigned T_COL      = 3,
  parameter int unsigned CNT_W      = 16,
  parameter bit          CLOSE_PAGE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  output logic             cmd_pre_o,
  output logic             cmd_act_o,
  output logic             cmd_rd_o,
  output logic             cmd_wr_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic             done_o,
  output logic [1:0]       outcome_o,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o,
  output logic [CNT_W-1:0] conf_cnt_o
);
  localparam int unsigned T_MAX = (T_PRE > T_ACT) ? ((T_PRE > T_COL) ? T_PRE : T_COL)
                                                  : ((T_ACT > T_COL) ? T_ACT : T_COL);
  localparam int unsigned TMR_W = $clog2(T_MAX + 1);

  rb_state_e        state_q, state_d;
  logic             first_q;
  logic             wr_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  rb_outc_e         outc_q;
  rb_outc_e         look_outc;
  logic             accept;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             col_exit;
  logic             rt_clr;
  logic             bg_start;
  logic             bg_long;
  logic             bg_pre_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign bg_start    = CLOSE_PAGE && col_exit;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    col_exit = 1'b0;
    rt_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        unique case (look_outc)
          RB_HIT: begin
            state_d  = ST_COL;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_COL - 1);
          end
          RB_EMPTY: begin
            if (bg_long) state_d = ST_WAIT;
            else begin
              state_d  = ST_ACT;
              tmr_load = 1'b1;
              tmr_val  = TMR_W'(T_ACT - 1);
            end
          end
          default: begin
            state_d  = ST_PRE;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(T_PRE - 1);
            rt_clr   = 1'b1;
          end
        endcase
      end
      ST_WAIT: if (!bg_long) begin
        state_d  = ST_ACT;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_ACT - 1);
      end
      ST_PRE: if (tmr_zero) begin
        state_d  = ST_ACT;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_ACT - 1);
      end
      ST_ACT: if (tmr_zero) begin
        state_d  = ST_COL;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_COL - 1);
      end
      ST_COL: if (tmr_zero) begin
        state_d  = ST_IDLE;
        col_exit = 1'b1;
        rt_clr   = CLOSE_PAGE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      first_q   <= 1'b0;
      wr_q      <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      outc_q    <= RB_EMPTY;
      done_o    <= 1'b0;
      outcome_o <= 2'd0;
      bg_pre_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      first_q  <= (state_d != state_q);
      done_o   <= col_exit;
      bg_pre_q <= bg_start;
      if (col_exit) outcome_o <= outc_q;
      if (accept) begin
        wr_q   <= req_write_i;
        row_q  <= req_row_i;
        col_q  <= req_col_i;
        outc_q <= look_outc;
      end
    end
  end

  dram_rb_phase_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  // row becomes valid at the activate strobe
  dram_rb_row_track #(.ROW_W(ROW_W)) u_rows (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (cmd_act_o),
    .clr_i       (rt_clr),
    .set_row_i   (row_q),
    .look_row_i  (req_row_i),
    .look_outc_o (look_outc)
  );

  generate
    if (CLOSE_PAGE) begin : g_bg
      dram_rb_bg_pre #(.T_PRE(T_PRE)) u_bg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (bg_start),
        .long_o  (bg_long)
      );
    end else begin : g_no_bg
      assign bg_long = 1'b0;
    end
  endgenerate

  logic [RB_NUM_OUTC-1:0] cnt_inc;
  logic [CNT_W-1:0]       cnt_v [RB_NUM_OUTC];

  for (genvar g = 0; g < RB_NUM_OUTC; g++) begin : g_cnt
    assign cnt_inc[g] = col_exit && (outc_q == rb_outc_e'(2'(g)));
    dram_rb_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (cnt_inc[g]),
      .cnt_o  (cnt_v[g])
    );
  end

  assign hit_cnt_o  = cnt_v[RB_HIT];
  assign miss_cnt_o = cnt_v[RB_EMPTY];
  assign conf_cnt_o = cnt_v[RB_CONFLICT];

  assign cmd_pre_o = ((state_q == ST_PRE) && first_q) || bg_pre_q;
  assign cmd_act_o = (state_q == ST_ACT) && first_q;
  assign cmd_rd_o  = (state_q == ST_COL) && first_q && !wr_q;
  assign cmd_wr_o  = (state_q == ST_COL) && first_q && wr_q;
  assign cmd_row_o = row_q;
  assign cmd_col_o = col_q;
endmodule

// File: rtl/dram_rowbuf_ctrl_chk.sv
module dram_rowbuf_ctrl_chk #(
  parameter int unsigned T_PRE      = 4,
  parameter int unsigned T_ACT      = 4,
  parameter int unsigned T_COL      = 3,
  parameter int unsigned CNT_W      = 16,
  parameter bit          CLOSE_PAGE = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             cmd_pre_o,
  input logic             cmd_act_o,
  input logic             cmd_rd_o,
  input logic             cmd_wr_o,
  input logic             done_o,
  input logic [1:0]       outcome_o,
  input logic [CNT_W-1:0] hit_cnt_o,
  input logic [CNT_W-1:0] miss_cnt_o,
  input logic [CNT_W-1:0] conf_cnt_o
);
  localparam int unsigned T_MAX = (T_PRE > T_ACT) ? ((T_PRE > T_COL) ? T_PRE : T_COL)
                                                  : ((T_ACT > T_COL) ? T_ACT : T_COL);
  localparam int unsigned AGE_W = $clog2(T_MAX + 2) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] pre_age, act_age, col_age;
  logic             col_cmd;
  assign col_cmd = cmd_rd_o || cmd_wr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_age <= AGE_MAX;
      act_age <= AGE_MAX;
      col_age <= AGE_MAX;
    end else begin
      pre_age <= cmd_pre_o ? AGE_W'(1) : ((pre_age == AGE_MAX) ? pre_age : pre_age + 1'b1);
      act_age <= cmd_act_o ? AGE_W'(1) : ((act_age == AGE_MAX) ? act_age : act_age + 1'b1);
      col_age <= col_cmd   ? AGE_W'(1) : ((col_age == AGE_MAX) ? col_age : col_age + 1'b1);
    end
  end

  // R4
  act_after_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_act_o |-> (pre_age >= AGE_W'(T_PRE)));

  // R4
  col_after_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_cmd |-> (act_age >= AGE_W'(T_ACT)));

  // R2
  done_after_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (col_age == AGE_W'(T_COL)));

  // R8
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_pre_o, cmd_act_o, cmd_rd_o, cmd_wr_o}));

  // R6
  close_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CLOSE_PAGE && done_o) |-> (cmd_pre_o && outcome_o == 2'd1));

  // R11
  cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt_o >= $past(hit_cnt_o)) && (miss_cnt_o >= $past(miss_cnt_o))
    && (conf_cnt_o >= $past(conf_cnt_o)));
endmodule

bind dram_rowbuf_ctrl dram_rowbuf_ctrl_chk #(
  .T_PRE(T_PRE), .T_ACT(T_ACT), .T_COL(T_COL), .CNT_W(CNT_W), .CLOSE_PAGE(CLOSE_PAGE)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cmd_pre_o   (cmd_pre_o),
  .cmd_act_o   (cmd_act_o),
  .cmd_rd_o    (cmd_rd_o),
  .cmd_wr_o    (cmd_wr_o),
  .done_o      (done_o),
  .outcome_o   (outcome_o),
  .hit_cnt_o   (hit_cnt_o),
  .miss_cnt_o  (miss_cnt_o),
  .conf_cnt_o  (conf_cnt_o)
);

// File: tb/dram_rowbuf_ctrl_tb_env.sv
module dram_rowbuf_ctrl_tb_env #(
  parameter bit CLOSE_PAGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic finished,
  output int   checks,
  output int   fails
);
  localparam int ROW_W = 6;
  localparam int COL_W = 5;
  localparam int T_PRE = 4;
  localparam int T_ACT = 4;
  localparam int T_COL = 3;
  localparam int CNT_W = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic             req_valid, req_ready, req_write;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             cmd_pre, cmd_act, cmd_rd, cmd_wr, done;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [1:0]       outcome;
  logic [CNT_W-1:0] hit_cnt, miss_cnt, conf_cnt;

  dram_rowbuf_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_PRE(T_PRE), .T_ACT(T_ACT), .T_COL(T_COL),
    .CNT_W(CNT_W), .CLOSE_PAGE(CLOSE_PAGE)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_row_i(req_row), .req_col_i(req_col),
    .cmd_pre_o(cmd_pre), .cmd_act_o(cmd_act), .cmd_rd_o(cmd_rd), .cmd_wr_o(cmd_wr),
    .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .done_o(done), .outcome_o(outcome),
    .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt), .conf_cnt_o(conf_cnt)
  );

  typedef struct {
    int    outc;
    int    done_cyc;
    bit    wr;
    int    row;
    int    col;
    int    pre_n;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc;
  bit   m_valid;
  int   m_row;
  int   m_last_done;
  bit   m_any;
  int   n_hit, n_miss, n_conf;
  int   pre_n, act_n, col_n;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s (close=%0d): actual %0d expected %0d",
               req, what, CLOSE_PAGE, act, expv);
    end
  endtask

  task automatic send(input bit wr, input int row, input int col, input int gap);
    exp_t e;
    int   a, start;
    repeat (gap) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_row   = ROW_W'(row);
    req_col   = COL_W'(col);
    while (!req_ready) @(negedge clk);
    a = cyc + 1;
    if (CLOSE_PAGE) begin
      e.outc  = 1;
      start   = (m_any && (m_last_done + T_PRE > a)) ? m_last_done + T_PRE : a;
      e.done_cyc = start + T_ACT + T_COL;
      e.pre_n = m_any ? 1 : 0;
      e.req   = "R7";
    end else begin
      if (!m_valid) begin
        e.outc = 1; e.done_cyc = a + T_ACT + T_COL; e.req = "R3";
      end else if (row == m_row) begin
        e.outc = 0; e.done_cyc = a + T_COL; e.req = "R2";
      end else begin
        e.outc = 2; e.done_cyc = a + T_PRE + T_ACT + T_COL; e.req = "R4";
      end
      e.pre_n = (e.outc == 2) ? 1 : 0;
      m_valid = 1'b1;
      m_row   = row;
    end
    e.wr  = wr;
    e.row = row;
    e.col = col;
    if (e.outc == 0) n_hit++;
    else if (e.outc == 1) n_miss++;
    else n_conf++;
    m_last_done = e.done_cyc;
    m_any = 1'b1;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "ready after accept", int'(req_ready), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (q.size() == 0) chk(1'b0, "R9", "done with nothing outstanding", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(outcome) == e.outc, e.req, "outcome", int'(outcome), e.outc);
          chk(cyc == e.done_cyc, e.req, "done cycle", cyc, e.done_cyc);
          chk(act_n == ((e.outc != 0) ? 1 : 0), e.req, "activate count", act_n,
              (e.outc != 0) ? 1 : 0);
          chk(col_n == 1, e.req, "column command count", col_n, 1);
          chk(pre_n == e.pre_n, e.req, "precharge count", pre_n, e.pre_n);
        end
        pre_n = 0;
        act_n = 0;
        col_n = 0;
      end
      if (cmd_pre) pre_n++;
      if (cmd_act) begin
        act_n++;
        if (q.size() > 0)
          chk(int'(cmd_row) == q[0].row, "R10", "activate row", int'(cmd_row), q[0].row);
      end
      if (cmd_rd || cmd_wr) begin
        col_n++;
        if (q.size() > 0) begin
          chk(cmd_wr == q[0].wr, "R10", "write strobe", int'(cmd_wr), int'(q[0].wr));
          chk(int'(cmd_col) == q[0].col, "R10", "column address", int'(cmd_col), q[0].col);
        end
      end
    end
  end

  initial begin
    finished = 1'b0;
    checks = 0;
    fails = 0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_row = '0;
    req_col = '0;
    m_valid = 1'b0;
    m_any = 1'b0;
    m_row = 0;
    m_last_done = 0;
    n_hit = 0; n_miss = 0; n_conf = 0;
    pre_n = 0; act_n = 0; col_n = 0;
    @(posedge rst_n);
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    chk({cmd_pre, cmd_act, cmd_rd, cmd_wr} == 4'b0, "R1", "commands",
        int'({cmd_pre, cmd_act, cmd_rd, cmd_wr}), 0);
    chk(hit_cnt == 0 && miss_cnt == 0 && conf_cnt == 0, "R1", "counters",
        int'(hit_cnt) + int'(miss_cnt) + int'(conf_cnt), 0);
    if (!CLOSE_PAGE) begin
      // R5: open row retained, hit then conflict
      send(1'b0, 5, 1, 0);
      send(1'b1, 5, 3, 0);
      send(1'b0, 5, 7, 2);
      send(1'b1, 9, 0, 0);
      send(1'b0, 9, 31, 1);
      send(1'b1, 2, 12, 0);
      for (int i = 0; i < 16; i++) send(i[0], 2, i, i % 3);
    end else begin
      // R6 / R7: background precharge, back-to-back and spaced
      send(1'b0, 5, 1, 0);
      send(1'b0, 5, 2, 0);
      send(1'b1, 5, 3, 2);
      send(1'b1, 7, 4, 10);
      send(1'b0, 8, 5, 0);
      send(1'b0, 8, 6, 1);
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    // R11 saturating counters, R5/R6 class tallies
    chk(int'(hit_cnt) == ((n_hit > CNT_MAX) ? CNT_MAX : n_hit), "R11", "hit counter",
        int'(hit_cnt), (n_hit > CNT_MAX) ? CNT_MAX : n_hit);
    chk(int'(miss_cnt) == ((n_miss > CNT_MAX) ? CNT_MAX : n_miss), "R11", "miss counter",
        int'(miss_cnt), (n_miss > CNT_MAX) ? CNT_MAX : n_miss);
    chk(int'(conf_cnt) == n_conf, "R5", "conflict counter", int'(conf_cnt), n_conf);
    if (CLOSE_PAGE)
      chk(hit_cnt == 0 && conf_cnt == 0, "R6", "no hit or conflict",
          int'(hit_cnt) + int'(conf_cnt), 0);
    finished = 1'b1;
  end
endmodule

// File: tb/dram_rowbuf_ctrl_tb_top.sv
module dram_rowbuf_ctrl_tb_top;
  logic clk;
  logic rst_n;
  logic fin_open, fin_close;
  int   chk_open, chk_close, fail_open, fail_close;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  dram_rowbuf_ctrl_tb_env #(.CLOSE_PAGE(1'b0)) env_open_i (
    .clk(clk), .rst_n(rst_n), .finished(fin_open), .checks(chk_open), .fails(fail_open)
  );

  dram_rowbuf_ctrl_tb_env #(.CLOSE_PAGE(1'b1)) env_close_i (
    .clk(clk), .rst_n(rst_n), .finished(fin_close), .checks(chk_close), .fails(fail_close)
  );

  initial begin
    int n;
    int total, bad;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    n = 0;
    while (!(fin_open && fin_close) && n < 20000) begin
      @(posedge clk);
      n++;
    end
    total = chk_open + chk_close;
    bad   = fail_open + fail_close;
    if (!(fin_open && fin_close)) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected < 20000", n);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", total, bad);
    $finish;
  end
endmodule